// File: doc/BRIEF.md
# Endpoint Bank Status Tracker

This block follows the state of one device-side endpoint whose data buffer is split into one to three banks. It counts the bytes held in each bank, knows which bank the processor is working on and how many banks are currently owned by the bus side, and from that decides whether the processor may move another byte. The meaning of the count and of the access flag follows the endpoint direction: toward the host the processor fills banks and the bus drains them, from the host the bus fills banks and the processor drains them.

An allocate strobe latches the bank count and bank size codes and checks them against the endpoint limits and a shared buffer RAM budget, clearing all bank state. A SETUP event records whether the following control packet travels toward the host. All results appear on one read-only status word; the block has no write path into it.

Top module: `ep_bank_status`

## Requirements
- R1: With `ep_is_in` high, each `cpu_wr_stb` adds one to the byte count of the processor's bank and each `usb_tx_stb` removes one from the count of the bank being sent; the status count shows the processor's bank.
- R2: With `ep_is_in` low, each `usb_rx_stb` adds one to the bank being filled by the bus and each `cpu_rd_stb` removes one from the processor's bank.
- R3: Strobes for the other direction are ignored, a count never exceeds the bank size, never drops below zero, and byte strobes aimed at a bank the side does not own are ignored.
- R4: For a non-control IN endpoint the access flag is high exactly when the processor owns a bank (busy banks below the bank count) and that bank is below the bank size.
- R5: For a non-control OUT endpoint the access flag is high exactly when at least one bank is filled and the processor's bank holds at least one byte.
- R6: The access flag is low in the cycle after `stall_req` or `err_flag` is high, and is always low while `ep_is_ctrl` is high.
- R7: The access flag reflects an event one clock after it; the status byte count reflects it one clock later still.
- R8: The configuration-valid bit changes only on `alloc_stb`; it is set when the bank code (0..2 = one to three banks) is within the maximum bank count, the size code (bank bytes = 8 shifted left by the code) is within the endpoint maximum, and banks times bank bytes fits the RAM budget.
- R9: On `setup_stb` the control-direction bit takes `setup_next_in`; at any other time it holds.
- R10: When the processor releases its bank, the processor bank index advances modulo the bank count and the status count shows the stored count of the next bank.
- R11: The busy-bank count rises when a bank passes to the bus side (IN: processor release; OUT: bus bank done) and falls when it returns (IN: bus bank done; OUT: processor release), staying within 0 and the bank count.
- R12: Status layout with default parameters: bits 10:0 byte count, 12:11 processor bank index, 14:13 busy banks, 15 access flag, 16 configuration valid, 17 control direction; all zero during reset.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_is_in | input | 1 | Endpoint direction, high toward the host |
| ep_is_ctrl | input | 1 | Endpoint is a control endpoint |
| alloc_stb | input | 1 | Allocate and check configuration, clears bank state |
| alloc_bank_code | input | 2 | Bank count code |
| alloc_size_code | input | 3 | Bank size code |
| cpu_wr_stb | input | 1 | Processor wrote one byte |
| cpu_rd_stb | input | 1 | Processor read one byte |
| usb_tx_stb | input | 1 | One byte sent to the host |
| usb_rx_stb | input | 1 | One byte received from the host |
| cpu_bank_release | input | 1 | Processor hands its current bank over |
| usb_bank_done | input | 1 | Bus side finished a bank |
| setup_stb | input | 1 | SETUP packet received |
| setup_next_in | input | 1 | Next control packet travels toward the host |
| stall_req | input | 1 | Stall request active |
| err_flag | input | 1 | Error present |
| status_o | output | 18 | Read-only status word |

## Verification
The bench fills an IN bank to its exact size and watches the access flag drop one cycle before the count reaches the size; a design with the two outputs aligned, or counting past the size, shows a wrong count or flag in that cycle. It releases banks until all are busy and drains one through the bus, so a design that forgets to reload the count from the next bank or mismanages the busy counter shows a stale count. OUT reads past zero, strobes of the wrong direction and bus writes into a full ring check that nothing moves when it should not, and allocations just inside and just outside the RAM budget, the endpoint size limit and the illegal bank code catch an off-by-one in the validity rule.

// File: rtl/ep_bank_pkg.sv
package ep_bank_pkg;
    localparam int BK_CODE_W      = 2;
    localparam int SZ_CODE_W      = 3;
    localparam int MIN_BANK_BYTES = 8;
    localparam int MAX_SIZE_CODE  = (1 << SZ_CODE_W) - 1;

    function automatic int bank_bytes(input logic [SZ_CODE_W-1:0] code);
        return MIN_BANK_BYTES << code;
    endfunction
endpackage

// File: rtl/ep_cfg_check.sv
module ep_cfg_check
    import ep_bank_pkg::*;
#(
    parameter int MAX_BANKS         = 3,
    parameter int EP_MAX_SIZE_CODE  = 6,
    parameter int RAM_BYTES         = 1024,
    parameter int CNT_W             = 11,
    localparam int NB_W             = $clog2(MAX_BANKS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_stb,
    input  logic [BK_CODE_W-1:0] bank_code,
    input  logic [SZ_CODE_W-1:0] size_code,
    output logic                 cfg_ok_o,
    output logic [NB_W-1:0]      nbanks_o,
    output logic [CNT_W-1:0]     bank_size_o
);
    typedef struct packed {
        logic                 ok;
        logic [NB_W-1:0]      nb;
        logic [SZ_CODE_W-1:0] sz;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    int   banks_req;
    int   total_bytes;

    always_comb begin
        cfg_d       = cfg_q;
        banks_req   = int'(bank_code) + 1;
        total_bytes = banks_req * bank_bytes(size_code);
        if (alloc_stb) begin
            cfg_d.ok = (banks_req <= MAX_BANKS) &&
                       (int'(size_code) <= EP_MAX_SIZE_CODE) &&
                       (total_bytes <= RAM_BYTES);
            cfg_d.nb = (banks_req <= MAX_BANKS) ? NB_W'(banks_req) : NB_W'(MAX_BANKS);
            cfg_d.sz = size_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.ok <= 1'b0;
            cfg_q.nb <= NB_W'(1);
            cfg_q.sz <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_ok_o    = cfg_q.ok;
    assign nbanks_o    = cfg_q.nb;
    assign bank_size_o = CNT_W'(bank_bytes(cfg_q.sz));

    // R8: validity only moves on an allocate strobe
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_stb |=> $stable(cfg_ok_o));
    // R11: bank count always within one and the maximum
    assert_nb_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (nbanks_o >= NB_W'(1)) && (nbanks_o <= NB_W'(MAX_BANKS)));
endmodule

// File: rtl/ep_bank_ctrl.sv
module ep_bank_ctrl #(
    parameter int MAX_BANKS = 3,
    parameter int CNT_W     = 11,
    localparam int NB_W     = $clog2(MAX_BANKS + 1),
    localparam int PTR_W    = (MAX_BANKS > 1) ? $clog2(MAX_BANKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             dir_in_i,
    input  logic             is_ctrl_i,
    input  logic [NB_W-1:0]  nbanks_i,
    input  logic [CNT_W-1:0] bank_size_i,
    input  logic             cpu_wr_i,
    input  logic             cpu_rd_i,
    input  logic             usb_tx_i,
    input  logic             usb_rx_i,
    input  logic             cpu_release_i,
    input  logic             usb_done_i,
    input  logic             stall_i,
    input  logic             err_i,
    output logic [PTR_W-1:0] cpu_ptr_o,
    output logic [NB_W-1:0]  busy_o,
    output logic             rw_ok_o,
    output logic [CNT_W-1:0] byte_cnt_o
);
    typedef struct packed {
        logic [MAX_BANKS-1:0][CNT_W-1:0] cnt;
        logic [PTR_W-1:0]                cpu_ptr;
        logic [PTR_W-1:0]                usb_ptr;
        logic [NB_W-1:0]                 busy;
        logic                            rw;
        logic [CNT_W-1:0]                byct;
    } bk_t;

    bk_t st_d, st_q;

    logic [CNT_W-1:0] cpu_cnt, usb_cnt, cur_cnt_d;
    logic [PTR_W-1:0] inc_ptr, dec_ptr, cpu_nxt, usb_nxt;
    logic [NB_W-1:0]  cpu_inc, usb_inc;
    logic             inc_en, dec_en, cpu_go, usb_go;
    logic             has_free, has_full, rw_raw;

    always_comb begin
        cpu_cnt  = st_q.cnt[st_q.cpu_ptr];
        usb_cnt  = st_q.cnt[st_q.usb_ptr];
        has_free = st_q.busy < nbanks_i;
        has_full = st_q.busy != '0;
        cpu_inc  = NB_W'(st_q.cpu_ptr) + NB_W'(1);
        usb_inc  = NB_W'(st_q.usb_ptr) + NB_W'(1);
        cpu_nxt  = (cpu_inc >= nbanks_i) ? '0 : PTR_W'(cpu_inc);
        usb_nxt  = (usb_inc >= nbanks_i) ? '0 : PTR_W'(usb_inc);

        if (dir_in_i) begin
            inc_en  = cpu_wr_i && has_free && (cpu_cnt < bank_size_i);
            inc_ptr = st_q.cpu_ptr;
            dec_en  = usb_tx_i && has_full && (usb_cnt != '0);
            dec_ptr = st_q.usb_ptr;
            cpu_go  = cpu_release_i && has_free;
            usb_go  = usb_done_i && has_full;
        end else begin
            inc_en  = usb_rx_i && has_free && (usb_cnt < bank_size_i);
            inc_ptr = st_q.usb_ptr;
            dec_en  = cpu_rd_i && has_full && (cpu_cnt != '0);
            dec_ptr = st_q.cpu_ptr;
            cpu_go  = cpu_release_i && has_full;
            usb_go  = usb_done_i && has_free;
        end

        st_d = st_q;
        for (int b = 0; b < MAX_BANKS; b++) begin
            if (inc_en && (inc_ptr == PTR_W'(b)))
                st_d.cnt[b] = st_d.cnt[b] + CNT_W'(1);
            if (dec_en && (dec_ptr == PTR_W'(b)))
                st_d.cnt[b] = st_d.cnt[b] - CNT_W'(1);
        end

        if (cpu_go) begin
            st_d.cpu_ptr = cpu_nxt;
            if (!dir_in_i) st_d.cnt[st_q.cpu_ptr] = '0;
        end
        if (usb_go) begin
            st_d.usb_ptr = usb_nxt;
            if (dir_in_i) st_d.cnt[st_q.usb_ptr] = '0;
        end

        if (dir_in_i)
            st_d.busy = st_q.busy + NB_W'(cpu_go) - NB_W'(usb_go);
        else
            st_d.busy = st_q.busy + NB_W'(usb_go) - NB_W'(cpu_go);

        if (clear_i) begin
            st_d.cnt     = '0;
            st_d.cpu_ptr = '0;
            st_d.usb_ptr = '0;
            st_d.busy    = '0;
        end

        cur_cnt_d = st_d.cnt[st_d.cpu_ptr];
        if (dir_in_i)
            rw_raw = (st_d.busy < nbanks_i) && (cur_cnt_d < bank_size_i);
        else
            rw_raw = (st_d.busy != '0) && (cur_cnt_d != '0);
        st_d.rw   = rw_raw && !stall_i && !err_i && !is_ctrl_i;
        // count display trails the flag by one cycle
        st_d.byct = cpu_cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpu_ptr_o  = st_q.cpu_ptr;
    assign busy_o     = st_q.busy;
    assign rw_ok_o    = st_q.rw;
    assign byte_cnt_o = st_q.byct;

    // R6: stall, error or control endpoint forces the flag low next cycle
    assert_rw_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i || err_i || is_ctrl_i) |=> !rw_ok_o);
    // R11: busy banks never exceed the configured bank count
    assert_busy_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o <= nbanks_i);
    // R3: the processor's bank never holds more than one bank of bytes
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt[st_q.cpu_ptr] <= bank_size_i);
    // R10: processor bank index stays inside the ring
    assert_ptr_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        NB_W'(cpu_ptr_o) < nbanks_i);
endmodule

// File: rtl/ep_bank_status.sv
module ep_bank_status
    import ep_bank_pkg::*;
#(
    parameter int MAX_BANKS        = 3,
    parameter int EP_MAX_SIZE_CODE = 6,
    parameter int RAM_BYTES        = 1024,
    localparam int CNT_W           = $clog2((MIN_BANK_BYTES << MAX_SIZE_CODE) + 1),
    localparam int NB_W            = $clog2(MAX_BANKS + 1),
    localparam int PTR_W           = (MAX_BANKS > 1) ? $clog2(MAX_BANKS) : 1,
    localparam int STS_W           = CNT_W + PTR_W + NB_W + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ep_is_in,
    input  logic                 ep_is_ctrl,
    input  logic                 alloc_stb,
    input  logic [BK_CODE_W-1:0] alloc_bank_code,
    input  logic [SZ_CODE_W-1:0] alloc_size_code,
    input  logic                 cpu_wr_stb,
    input  logic                 cpu_rd_stb,
    input  logic                 usb_tx_stb,
    input  logic                 usb_rx_stb,
    input  logic                 cpu_bank_release,
    input  logic                 usb_bank_done,
    input  logic                 setup_stb,
    input  logic                 setup_next_in,
    input  logic                 stall_req,
    input  logic                 err_flag,
    output logic [STS_W-1:0]     status_o
);
    logic             cfg_ok;
    logic [NB_W-1:0]  nbanks;
    logic [CNT_W-1:0] bank_size;
    logic [PTR_W-1:0] cpu_ptr;
    logic [NB_W-1:0]  busy;
    logic             rw_ok;
    logic [CNT_W-1:0] byte_cnt;
    logic             dir_d, dir_q;

    ep_cfg_check #(
        .MAX_BANKS       (MAX_BANKS),
        .EP_MAX_SIZE_CODE(EP_MAX_SIZE_CODE),
        .RAM_BYTES       (RAM_BYTES),
        .CNT_W           (CNT_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_stb  (alloc_stb),
        .bank_code  (alloc_bank_code),
        .size_code  (alloc_size_code),
        .cfg_ok_o   (cfg_ok),
        .nbanks_o   (nbanks),
        .bank_size_o(bank_size)
    );

    ep_bank_ctrl #(
        .MAX_BANKS(MAX_BANKS),
        .CNT_W    (CNT_W)
    ) u_banks (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (alloc_stb),
        .dir_in_i     (ep_is_in),
        .is_ctrl_i    (ep_is_ctrl),
        .nbanks_i     (nbanks),
        .bank_size_i  (bank_size),
        .cpu_wr_i     (cpu_wr_stb),
        .cpu_rd_i     (cpu_rd_stb),
        .usb_tx_i     (usb_tx_stb),
        .usb_rx_i     (usb_rx_stb),
        .cpu_release_i(cpu_bank_release),
        .usb_done_i   (usb_bank_done),
        .stall_i      (stall_req),
        .err_i        (err_flag),
        .cpu_ptr_o    (cpu_ptr),
        .busy_o       (busy),
        .rw_ok_o      (rw_ok),
        .byte_cnt_o   (byte_cnt)
    );

    always_comb begin
        dir_d = dir_q;
        if (setup_stb) dir_d = setup_next_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dir_q <= 1'b0;
        else        dir_q <= dir_d;
    end

    assign status_o = {dir_q, cfg_ok, rw_ok, busy, cpu_ptr, byte_cnt};

    // R9: direction bit only follows a SETUP event
    assert_dir_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !setup_stb |=> $stable(dir_q));
    // R9: after a SETUP event the bit equals the sampled direction
    assert_dir_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        setup_stb |=> (dir_q == $past(setup_next_in)));
endmodule

// File: tb/ep_bank_status_bench.sv
module ep_bank_status_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ep_is_in = 1'b0, ep_is_ctrl = 1'b0, alloc_stb = 1'b0;
    logic [1:0] alloc_bank_code = '0;
    logic [2:0] alloc_size_code = '0;
    logic cpu_wr_stb = 1'b0, cpu_rd_stb = 1'b0, usb_tx_stb = 1'b0, usb_rx_stb = 1'b0;
    logic cpu_bank_release = 1'b0, usb_bank_done = 1'b0;
    logic setup_stb = 1'b0, setup_next_in = 1'b0, stall_req = 1'b0, err_flag = 1'b0;
    logic [17:0] status_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string       req;
        logic [17:0] exp;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    ep_bank_status u_ep_bank_status (
        .clk(clk), .rst_n(rst_n), .ep_is_in(ep_is_in), .ep_is_ctrl(ep_is_ctrl),
        .alloc_stb(alloc_stb), .alloc_bank_code(alloc_bank_code),
        .alloc_size_code(alloc_size_code), .cpu_wr_stb(cpu_wr_stb),
        .cpu_rd_stb(cpu_rd_stb), .usb_tx_stb(usb_tx_stb), .usb_rx_stb(usb_rx_stb),
        .cpu_bank_release(cpu_bank_release), .usb_bank_done(usb_bank_done),
        .setup_stb(setup_stb), .setup_next_in(setup_next_in),
        .stall_req(stall_req), .err_flag(err_flag), .status_o(status_o)
    );

    // R12 layout: [10:0] count, [12:11] bank, [14:13] busy, 15 rw, 16 cfg, 17 dir
    function automatic logic [17:0] pack(int byct, int bank, int busy, bit rw, bit cfg, bit dir);
        return {dir, cfg, rw, 2'(busy), 2'(bank), 11'(byct)};
    endfunction

    task automatic expect_sts(string req, logic [17:0] exp);
        item_t it;
        it.req = req;
        it.exp = exp;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            wait (sb_q.size() > 0);
            it = sb_q.pop_front();
            checks++;
            if (status_o !== it.exp) begin
                errors++;
                $display("FAIL %s: status actual=%h expected=%h", it.req, status_o, it.exp);
            end
        end
    end

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    // which: 0 wr, 1 rd, 2 tx, 3 rx, 4 cpu release, 5 usb done, 6 setup
    task automatic pulse(int which, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            case (which)
                0: cpu_wr_stb = 1'b1;
                1: cpu_rd_stb = 1'b1;
                2: usb_tx_stb = 1'b1;
                3: usb_rx_stb = 1'b1;
                4: cpu_bank_release = 1'b1;
                5: usb_bank_done = 1'b1;
                default: setup_stb = 1'b1;
            endcase
            @(negedge clk);
            {cpu_wr_stb, cpu_rd_stb, usb_tx_stb, usb_rx_stb} = '0;
            {cpu_bank_release, usb_bank_done, setup_stb} = '0;
        end
    endtask

    task automatic alloc(int bcode, int scode);
        @(negedge clk);
        alloc_bank_code = 2'(bcode);
        alloc_size_code = 3'(scode);
        alloc_stb = 1'b1;
        @(negedge clk);
        alloc_stb = 1'b0;
        settle();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        expect_sts("R12 reset", pack(0, 0, 0, 0, 0, 0));
        rst_n = 1'b1;
        ep_is_in = 1'b1;
        settle();
        expect_sts("R4 idle after reset", pack(0, 0, 0, 1, 0, 0));

        // IN endpoint, two banks of 32 bytes
        alloc(1, 2);
        expect_sts("R8 alloc valid", pack(0, 0, 0, 1, 1, 0));
        pulse(0, 5); settle();
        expect_sts("R1 cpu writes", pack(5, 0, 0, 1, 1, 0));
        pulse(1, 3); settle();
        expect_sts("R3 read ignored on IN", pack(5, 0, 0, 1, 1, 0));
        pulse(4, 1); settle();
        expect_sts("R10 R11 release advances", pack(0, 1, 1, 1, 1, 0));
        pulse(0, 31); settle();
        expect_sts("R1 bank nearly full", pack(31, 1, 1, 1, 1, 0));
        @(negedge clk); cpu_wr_stb = 1'b1;
        @(negedge clk); cpu_wr_stb = 1'b0;
        expect_sts("R7 flag before count", pack(31, 1, 1, 0, 1, 0));
        @(negedge clk);
        expect_sts("R7 R4 count follows", pack(32, 1, 1, 0, 1, 0));
        pulse(0, 1); settle();
        expect_sts("R3 no overflow", pack(32, 1, 1, 0, 1, 0));
        pulse(4, 1); settle();
        expect_sts("R10 R11 R4 all busy reload", pack(5, 0, 2, 0, 1, 0));
        pulse(2, 2); settle();
        expect_sts("R1 bytes sent", pack(3, 0, 2, 0, 1, 0));
        pulse(5, 1); settle();
        expect_sts("R11 R4 bank returned", pack(0, 0, 1, 1, 1, 0));
        stall_req = 1'b1; settle();
        expect_sts("R6 stall", pack(0, 0, 1, 0, 1, 0));
        stall_req = 1'b0; settle();
        expect_sts("R6 stall released", pack(0, 0, 1, 1, 1, 0));
        err_flag = 1'b1; settle();
        expect_sts("R6 error", pack(0, 0, 1, 0, 1, 0));
        err_flag = 1'b0; settle();

        // control direction
        setup_next_in = 1'b1; pulse(6, 1); settle();
        expect_sts("R9 setup IN", pack(0, 0, 1, 1, 1, 1));
        setup_next_in = 1'b0; pulse(6, 1); settle();
        expect_sts("R9 setup OUT", pack(0, 0, 1, 1, 1, 0));
        setup_next_in = 1'b1; settle();
        expect_sts("R9 hold without setup", pack(0, 0, 1, 1, 1, 0));

        // configuration checks against RAM 1024, endpoint max code 6
        alloc(1, 6);
        expect_sts("R8 fits budget exactly", pack(0, 0, 0, 1, 1, 0));
        alloc(2, 6);
        expect_sts("R8 over RAM budget", pack(0, 0, 0, 1, 0, 0));
        alloc_bank_code = 2'd0; alloc_size_code = 3'd0; settle();
        expect_sts("R8 hold without alloc", pack(0, 0, 0, 1, 0, 0));
        alloc(1, 2);
        alloc(0, 7);
        expect_sts("R8 size over endpoint max", pack(0, 0, 0, 1, 0, 0));
        alloc(3, 0);
        expect_sts("R8 illegal bank code", pack(0, 0, 0, 1, 0, 0));

        // OUT endpoint, one bank of 8 bytes
        ep_is_in = 1'b0;
        alloc(0, 0);
        expect_sts("R5 OUT empty", pack(0, 0, 0, 0, 1, 0));
        pulse(3, 3); settle();
        expect_sts("R2 bytes received", pack(3, 0, 0, 0, 1, 0));
        pulse(5, 1); settle();
        expect_sts("R5 R11 bank filled", pack(3, 0, 1, 1, 1, 0));
        pulse(0, 2); settle();
        expect_sts("R3 write ignored on OUT", pack(3, 0, 1, 1, 1, 0));
        pulse(3, 1); settle();
        expect_sts("R3 rx into busy ring ignored", pack(3, 0, 1, 1, 1, 0));
        pulse(1, 3); settle();
        expect_sts("R2 R5 read empty", pack(0, 0, 1, 0, 1, 0));
        pulse(1, 1); settle();
        expect_sts("R3 no underflow", pack(0, 0, 1, 0, 1, 0));
        pulse(4, 1); settle();
        expect_sts("R11 released", pack(0, 0, 0, 0, 1, 0));

        // control endpoint
        ep_is_in = 1'b1;
        ep_is_ctrl = 1'b1;
        alloc(0, 0);
        expect_sts("R6 control keeps flag low", pack(0, 0, 0, 0, 1, 0));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule